// File: doc/BRIEF.md
# Processor Clock-Stop and Sleep State Controller

This block decides, cycle by cycle, which clock domains of a processor core may run. Two active-low request pins drive it: a clock-stop request and a sleep request. With neither asserted the core runs. Asserting the clock-stop request halts the core clocks, after a single acknowledge cycle. The bus and interrupt-controller clocks keep running, and snoops and interrupts are still taken. The sleep request has an effect only in that grant state. It moves the controller into sleep, where every clock enable is off and snoop and interrupt requests are blocked.

Sleep has a single way out. Releasing the sleep request always lands in the grant state, never straight back to running, and the bus and interrupt-controller clocks restart there. The phase-locked loop is represented only by a status output that stays high. Both request pins pass through a parameterised synchroniser. The active-low reset pin returns the controller to the running state at once, without waiting for a clock edge.

Top module: `pwr_sleep_ctl`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `pwr_state` is 0 (run). In that state `core_clk_en`=1, `bus_clk_en`=1, `stop_ack`=0, `snoop_mask`=0, `irq_mask`=0 and `pll_run`=1. The reset acts without a clock edge.
- R2: With `stpclk_n` low in the run state, the controller passes through state 1 (acknowledge). In that state `stop_ack`=1 for exactly one cycle. It then moves to state 2 (grant), where `core_clk_en`=0 and `bus_clk_en`=1.
- R3: In the grant state, with `stpclk_n` high and `slp_n` high, the controller returns to the run state and `core_clk_en` goes back to 1.
- R4: In the grant state, `slp_n` low moves the controller to state 3 (sleep). This happens whatever `stpclk_n` does. In sleep, `core_clk_en`=0 and `bus_clk_en`=0.
- R5: `slp_n` has no effect in the run state. A low `slp_n` there neither changes the state nor stops the move into the acknowledge state.
- R6: `pll_run` is 1 in every state, sleep included.
- R7: In sleep, `snoop_mask`=1 and `irq_mask`=1. `snoop_take` and every bit of `irq_take` are then 0, whatever the requests are.
- R8: In sleep, `slp_n` high returns the controller to the grant state, even when `stpclk_n` is also high. In the grant state `bus_clk_en`=1 and `core_clk_en`=0.
- R9: In sleep, while `slp_n` stays low, changes on `stpclk_n` leave the controller in sleep.
- R10: Outside sleep, `snoop_take` equals `snoop_req` and `irq_take` equals `irq_req`.
- R11: A change on a request pin shows on the state and enable outputs after exactly SYNC_STAGES+1 rising clock edges, and not before.
- R12: The clock enables, masks and acknowledge are registered. They change on the same edge as `pwr_state` and always agree with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stpclk_n | input | 1 | Clock-stop request, active low |
| slp_n | input | 1 | Sleep request, active low |
| snoop_req | input | 1 | Incoming snoop request |
| irq_req | input | NUM_IRQ | Incoming interrupt requests |
| core_clk_en | output | 1 | Clock enable for core units |
| bus_clk_en | output | 1 | Clock enable for bus and interrupt-controller units |
| pll_run | output | 1 | Phase-locked loop running indication |
| stop_ack | output | 1 | One-cycle acknowledge of the clock-stop request |
| snoop_mask | output | 1 | Snoops blocked |
| irq_mask | output | 1 | Interrupts blocked |
| snoop_take | output | 1 | Snoop request passed on to the core |
| irq_take | output | NUM_IRQ | Interrupt requests passed on to the core |
| pwr_state | output | 2 | State code: 0 run, 1 acknowledge, 2 grant, 3 sleep |

## Verification
The bench starts from each stable state and applies all four combinations of the two request pins. Each outcome is compared with an independent next-state model, exactly SYNC_STAGES+1 edges later. This catches a sleep request honoured in the run state, which would skip the acknowledge. It also catches a sleep exit that goes straight to running, and a clock-stop release honoured while asleep. The acknowledge is timed to a single cycle, which would reveal a pulse that is stretched or missing. Snoop and interrupt requests are raised in every state, which exposes a mask that lets requests through in sleep or blocks them while awake. A check one edge before the expected change would flag a synchroniser with the wrong depth.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;

   // State codes; the encoding is visible on the pwr_state port.
   typedef enum logic [1:0] {
      PS_RUN   = 2'd0,
      PS_ACK   = 2'd1,
      PS_GRANT = 2'd2,
      PS_SLEEP = 2'd3
   } pwr_state_e;

   localparam int unsigned PWR_STATE_W = 2;
   localparam int unsigned MAX_SYNC    = 4;

   // Core clocks run only before the grant is reached.
   function automatic logic core_on(pwr_state_e s);
      return (s == PS_RUN) || (s == PS_ACK);
   endfunction

   // Bus and interrupt-controller clocks stop only in sleep.
   function automatic logic bus_on(pwr_state_e s);
      return s != PS_SLEEP;
   endfunction

endpackage

// File: rtl/pwr_pin_sync.sv
module pwr_pin_sync #(
   parameter int unsigned STAGES    = 2,
   parameter int unsigned WIDTH     = 1,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [WIDTH-1:0] stg [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
               stg[i] <= {WIDTH{RESET_VAL}};
            end
         end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
               stg[i] <= stg[i-1];
            end
         end
      end

      assign q = stg[STAGES-1];
   end

endmodule

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl
   import pwr_sleep_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stop_act,
   input  logic       sleep_act,
   output pwr_state_e state_q,
   output pwr_state_e state_nxt
);

   always_comb begin
      state_nxt = state_q;
      unique case (state_q)
         PS_RUN:   if (stop_act) state_nxt = PS_ACK;
         PS_ACK:   state_nxt = PS_GRANT;
         PS_GRANT: begin
            if (sleep_act)      state_nxt = PS_SLEEP;
            else if (!stop_act) state_nxt = PS_RUN;
         end
         PS_SLEEP: if (!sleep_act) state_nxt = PS_GRANT;
         default:  state_nxt = PS_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PS_RUN;
      else        state_q <= state_nxt;
   end

endmodule

// File: rtl/pwr_out_reg.sv
module pwr_out_reg
   import pwr_sleep_pkg::*;
#(
   parameter int unsigned NUM_IRQ = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  pwr_state_e         state_nxt,
   input  logic               snoop_req,
   input  logic [NUM_IRQ-1:0] irq_req,
   output logic               core_en,
   output logic               bus_en,
   output logic               ack,
   output logic               snoop_blk,
   output logic               irq_blk,
   output logic               snoop_out,
   output logic [NUM_IRQ-1:0] irq_out
);

   // Outputs are decoded from the next state so they switch on the same edge as the state.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         core_en   <= 1'b1;
         bus_en    <= 1'b1;
         ack       <= 1'b0;
         snoop_blk <= 1'b0;
         irq_blk   <= 1'b0;
      end else begin
         core_en   <= core_on(state_nxt);
         bus_en    <= bus_on(state_nxt);
         ack       <= (state_nxt == PS_ACK);
         snoop_blk <= (state_nxt == PS_SLEEP);
         irq_blk   <= (state_nxt == PS_SLEEP);
      end
   end

   assign snoop_out = snoop_req & ~snoop_blk;

   for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
      assign irq_out[g] = irq_req[g] & ~irq_blk;
   end

endmodule

// File: rtl/pwr_sleep_ctl.sv
module pwr_sleep_ctl
   import pwr_sleep_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned NUM_IRQ     = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               stpclk_n,
   input  logic               slp_n,
   input  logic               snoop_req,
   input  logic [NUM_IRQ-1:0] irq_req,
   output logic               core_clk_en,
   output logic               bus_clk_en,
   output logic               pll_run,
   output logic               stop_ack,
   output logic               snoop_mask,
   output logic               irq_mask,
   output logic               snoop_take,
   output logic [NUM_IRQ-1:0] irq_take,
   output logic [1:0]         pwr_state
);

   localparam int unsigned PIN_W = 2;

   if (SYNC_STAGES > MAX_SYNC) begin : g_bad_sync
      $error("pwr_sleep_ctl: SYNC_STAGES above supported maximum");
   end
   if (NUM_IRQ < 1) begin : g_bad_irq
      $error("pwr_sleep_ctl: NUM_IRQ must be at least 1");
   end

   logic [PIN_W-1:0] pins_raw;
   logic [PIN_W-1:0] pins_sync;
   pwr_state_e       st_q;
   pwr_state_e       st_nxt;

   assign pins_raw = {slp_n, stpclk_n};

   pwr_pin_sync #(
      .STAGES   (SYNC_STAGES),
      .WIDTH    (PIN_W),
      .RESET_VAL(1'b1)
   ) pin_sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pins_raw),
      .q    (pins_sync)
   );

   pwr_state_ctl state_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .stop_act (~pins_sync[0]),
      .sleep_act(~pins_sync[1]),
      .state_q  (st_q),
      .state_nxt(st_nxt)
   );

   pwr_out_reg #(
      .NUM_IRQ(NUM_IRQ)
   ) out_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .state_nxt(st_nxt),
      .snoop_req(snoop_req),
      .irq_req  (irq_req),
      .core_en  (core_clk_en),
      .bus_en   (bus_clk_en),
      .ack      (stop_ack),
      .snoop_blk(snoop_mask),
      .irq_blk  (irq_mask),
      .snoop_out(snoop_take),
      .irq_out  (irq_take)
   );

   assign pll_run   = 1'b1;
   assign pwr_state = st_q;

endmodule

// File: rtl/pwr_sleep_ctl_chk.sv
module pwr_sleep_ctl_chk #(
   parameter int unsigned NUM_IRQ = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [1:0]         pwr_state,
   input logic               core_clk_en,
   input logic               bus_clk_en,
   input logic               stop_ack,
   input logic               snoop_mask,
   input logic               snoop_take,
   input logic [NUM_IRQ-1:0] irq_take
);

   // R2: the acknowledge lasts one cycle and leads to the grant state.
   p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ack |=> !stop_ack);
   p_ack_to_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ack |=> (pwr_state == 2'd2));

   // R4: sleep is entered only from the grant state.
   p_sleep_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state != 2'd2 && pwr_state != 2'd3) |=> (pwr_state != 2'd3));
   p_sleep_clocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'd3) |-> (!core_clk_en && !bus_clk_en));

   // R7: nothing gets through while asleep.
   p_sleep_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'd3) |-> (!snoop_take && irq_take == '0));

   // R8: sleep leads only back to the grant state.
   p_sleep_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'd3) |=> (pwr_state == 2'd3 || pwr_state == 2'd2));

   // R12: registered enables agree with the state register.
   p_core_agree_r12: assert property (@(posedge clk) disable iff (!rst_n)
      core_clk_en == (pwr_state == 2'd0 || pwr_state == 2'd1));
   p_mask_agree_r12: assert property (@(posedge clk) disable iff (!rst_n)
      snoop_mask == (pwr_state == 2'd3));

endmodule

bind pwr_sleep_ctl pwr_sleep_ctl_chk #(.NUM_IRQ(NUM_IRQ)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .pwr_state  (pwr_state),
   .core_clk_en(core_clk_en),
   .bus_clk_en (bus_clk_en),
   .stop_ack   (stop_ack),
   .snoop_mask (snoop_mask),
   .snoop_take (snoop_take),
   .irq_take   (irq_take)
);

// File: tb/pwr_sleep_ctl_tb_top.sv
module pwr_sleep_ctl_tb_top;

   localparam int unsigned S  = 2;
   localparam int unsigned NI = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          stpclk_n;
   logic          slp_n;
   logic          snoop_req;
   logic [NI-1:0] irq_req;
   logic          core_clk_en, bus_clk_en, pll_run, stop_ack;
   logic          snoop_mask, irq_mask, snoop_take;
   logic [NI-1:0] irq_take;
   logic [1:0]    pwr_state;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk; // 125 MHz

   pwr_sleep_ctl #(.SYNC_STAGES(S), .NUM_IRQ(NI)) dut_i (
      .clk(clk), .rst_n(rst_n), .stpclk_n(stpclk_n), .slp_n(slp_n),
      .snoop_req(snoop_req), .irq_req(irq_req),
      .core_clk_en(core_clk_en), .bus_clk_en(bus_clk_en), .pll_run(pll_run),
      .stop_ack(stop_ack), .snoop_mask(snoop_mask), .irq_mask(irq_mask),
      .snoop_take(snoop_take), .irq_take(irq_take), .pwr_state(pwr_state)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Independent reference for the next state: 0 run, 1 ack, 2 grant, 3 sleep.
   function automatic int ref_next(int s, logic stp_n, logic sl_n);
      case (s)
         0: return stp_n ? 0 : 1;
         1: return 2;
         2: return !sl_n ? 3 : (stp_n ? 0 : 2);
         default: return sl_n ? 2 : 3;
      endcase
   endfunction

   task automatic edges(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check_outs(input string req, input int s);
      chk({req, " state"}, pwr_state, s);
      chk({req, " core_en"}, core_clk_en, (s <= 1) ? 1 : 0);
      chk({req, " bus_en"}, bus_clk_en, (s != 3) ? 1 : 0);
      chk({req, " ack"}, stop_ack, (s == 1) ? 1 : 0);
      chk({req, " mask"}, {30'd0, irq_mask, snoop_mask}, (s == 3) ? 3 : 0);
      chk("R6 pll_run", pll_run, 1);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; stpclk_n = 1'b1; slp_n = 1'b1;
      snoop_req = 1'b0; irq_req = '0;
      #1;
      check_outs("R1 during reset", 0);
      edges(2);
      rst_n = 1'b1;
      edges(1);
      check_outs("R1 after reset", 0);
   endtask

   task automatic go_to(input int s);
      do_reset();
      if (s >= 2) begin
         stpclk_n = 1'b0;
         edges(S + 2);
         check_outs("R2 reach grant", 2);
      end
      if (s == 3) begin
         slp_n = 1'b0;
         edges(S + 1);
         check_outs("R4 reach sleep", 3);
      end
   endtask

   initial begin
      rst_n = 1'b0; stpclk_n = 1'b1; slp_n = 1'b1;
      snoop_req = 1'b0; irq_req = '0;

      // R2 / R11: acknowledge pulse timing from run.
      do_reset();
      stpclk_n = 1'b0;
      edges(S);
      chk("R11 no early change", pwr_state, 0);
      edges(1);
      chk("R2 ack state", pwr_state, 1);
      chk("R2 ack high", stop_ack, 1);
      edges(1);
      chk("R2 ack one cycle", stop_ack, 0);
      check_outs("R2 grant", 2);

      // R3/R4/R5/R8/R9: sweep stable states against all pin combinations.
      for (int s = 0; s < 4; s++) begin
         if (s == 1) continue;
         for (int c = 0; c < 4; c++) begin
            logic stp_v, slp_v;
            int   e;
            stp_v = c[0];
            slp_v = c[1];
            go_to(s);
            stpclk_n = stp_v;
            slp_n    = slp_v;
            e = ref_next(s, stp_v, slp_v);
            edges(S + 1);
            if (s == 0)      check_outs("R5 run sweep", e);
            else if (s == 2) check_outs("R3 R4 grant sweep", e);
            else if (slp_v)  check_outs("R8 sleep exit", e);
            else             check_outs("R9 sleep hold", e);
            // R7 / R10: request gating in the reached state.
            snoop_req = 1'b1;
            irq_req   = '1;
            #1;
            chk("R7 R10 snoop_take", snoop_take, (e == 3) ? 0 : 1);
            chk("R7 R10 irq_take", irq_take, (e == 3) ? 0 : (1 << NI) - 1);
            snoop_req = 1'b0;
            irq_req   = 4'b0101;
            #1;
            chk("R10 irq pattern", irq_take, (e == 3) ? 0 : 5);
            irq_req = '0;
         end
      end

      // R12: asynchronous reset from sleep.
      go_to(3);
      #2;
      rst_n = 1'b0;
      #1;
      check_outs("R1 R12 async reset from sleep", 0);
      rst_n = 1'b1;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 100000; i++) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule